// File: doc/BRIEF.md
# Debug Mailbox Register with Dirty Flag

This block gives a running CPU a one-byte channel to an external debugger. The CPU writes a byte to one I/O address. The block stores the byte and raises a dirty flag. The debugger reads the byte and the flag on its own port. A one-cycle acknowledge from the debugger lowers the flag again. When the CPU reads the same address, it gets the low seven stored bits, and the dirty flag takes the place of bit 7.

The mailbox shares its address with an ordinary 8-bit I/O register. The CPU reaches the mailbox only when two conditions hold: the debug-enable fuse is programmed, and the debugger has raised its access-enable. In every other case, that address reaches the ordinary register.

The block also holds the lock bits and the debug-enable fuse bit, and it contains the guard that protects that fuse. While any lock bit is programmed, a request to program the fuse is refused. A chip erase clears the lock bits and so opens the guard again.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, the mailbox byte, the dirty flag, the ordinary register, the lock bits and the fuse are all 0, and a CPU read of the shared address returns 0x00.
- R2: When the mailbox path is open, a CPU write to the shared address stores the full byte and sets the dirty flag. Both are visible on the debugger port from the cycle after the write edge.
- R3: When the mailbox path is open, a CPU read of the shared address returns bit 7 = dirty flag and bits 6..0 = stored bits 6..0. The read data is combinational while the read strobe is high.
- R4: The debugger port always shows all 8 stored bits and the dirty flag. A one-cycle read-acknowledge clears the flag at the next edge and leaves the byte unchanged.
- R5: If a mailbox write and a read-acknowledge happen in the same cycle, the new byte is stored and the dirty flag stays set.
- R6: The mailbox path is open only when the fuse is 1 and access-enable is 1. Otherwise, CPU reads and writes of the shared address reach the ordinary register, which holds all 8 bits. In that case the mailbox byte and the dirty flag are unchanged.
- R7: A CPU write to any other address changes neither register, and a CPU read of any other address returns 0x00.
- R8: A lock-program pulse ORs its 2-bit value into the lock bits (1 = programmed).
- R9: A request to set the fuse to 1 while any lock bit is 1 is refused. The fuse is unchanged, and the refusal output is high for exactly the one cycle after the request edge.
- R10: A chip-erase pulse clears the lock bits, the mailbox byte and the dirty flag. It wins over a CPU write in the same cycle and leaves the fuse and the ordinary register alone. After it, a request to set the fuse is accepted.
- R11: A request to set the fuse to 0 is always accepted, and an accepted request never raises the refusal output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | ADDR_W | CPU I/O address |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuRdEn | input | 1 | CPU read strobe |
| cpuWrData | input | DATA_W | CPU write data |
| cpuRdData | output | DATA_W | CPU read data, combinational |
| dbgAccessEn | input | 1 | Debugger permits CPU access to the mailbox |
| dbgRdAck | input | 1 | Debugger has consumed the byte (pulse) |
| dbgData | output | DATA_W | Stored mailbox byte, all bits |
| dbgDirty | output | 1 | Dirty flag |
| chipErase | input | 1 | Chip-erase pulse |
| lockProgReq | input | 1 | Lock-program pulse |
| lockProgBits | input | LOCK_N | Lock bits to program |
| lockState | output | LOCK_N | Current lock bits |
| fuseWrReq | input | 1 | Fuse write request pulse |
| fuseWrVal | input | 1 | Value requested for the fuse |
| debugFuse | output | 1 | Current debug-enable fuse |
| fuseRefused | output | 1 | One-cycle refusal pulse |

## Verification
The bench sends every byte value through both the mailbox and the ordinary register. This catches a read mux that puts the stored bit 7 where the flag belongs, and a debugger port that drops bit 7. It tries all four combinations of fuse and access-enable on the shared address. An aliasing fault would show up as a write landing in the wrong register, or in both. It drives a write and an acknowledge in the same cycle, where a design with the wrong priority would lose the flag for fresh data. It also programs every non-zero lock pattern, checking that the guard refuses the fuse with a single-cycle pulse, and then checks that a chip erase reopens the guard. A chip erase in the same cycle as a write must leave the mailbox empty.

// File: rtl/dbg_mailbox_pkg.sv
package dbg_mailbox_pkg;

  // Strobes passed from the control module to the datapath, one cycle's worth.
  typedef struct packed {
    logic mboxWr;     // store CPU byte in mailbox
    logic stdWr;      // store CPU byte in ordinary register
    logic dirtySet;   // raise dirty flag
    logic dirtyClr;   // lower dirty flag
    logic erase;      // chip erase: wipe mailbox and flag
    logic mboxRdSel;  // drive mailbox view onto CPU read bus
    logic stdRdSel;   // drive ordinary register onto CPU read bus
  } mbxStrobe_t;

endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import dbg_mailbox_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LOCK_N = 2,
  parameter logic [ADDR_W-1:0] MBOX_ADDR = 6'h22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrEn,
  input  logic              cpuRdEn,
  input  logic              dbgAccessEn,
  input  logic              dbgRdAck,
  input  logic              chipErase,
  input  logic              lockProgReq,
  input  logic [LOCK_N-1:0] lockProgBits,
  input  logic              fuseWrReq,
  input  logic              fuseWrVal,
  output mbxStrobe_t        strb,
  output logic [LOCK_N-1:0] lockState,
  output logic              debugFuse,
  output logic              fuseRefused
);

  logic addrHit;
  logic mboxPath;
  logic refuseNow;
  logic acceptNow;

  assign addrHit   = (cpuAddr == MBOX_ADDR);
  assign mboxPath  = debugFuse & dbgAccessEn;
  assign refuseNow = fuseWrReq & fuseWrVal & (|lockState);
  assign acceptNow = fuseWrReq & ~refuseNow;

  always_comb begin
    strb           = '0;
    strb.mboxWr    = addrHit & cpuWrEn & mboxPath;
    strb.stdWr     = addrHit & cpuWrEn & ~mboxPath;
    strb.dirtySet  = addrHit & cpuWrEn & mboxPath;
    strb.dirtyClr  = dbgRdAck;
    strb.erase     = chipErase;
    strb.mboxRdSel = addrHit & cpuRdEn & mboxPath;
    strb.stdRdSel  = addrHit & cpuRdEn & ~mboxPath;
  end

  // Lock bits: programming only sets bits, erase clears them all.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockState <= '0;
    end else if (chipErase) begin
      lockState <= '0;
    end else if (lockProgReq) begin
      lockState <= lockState | lockProgBits;
    end
  end

  // Fuse bit with its lock guard.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      debugFuse   <= 1'b0;
      fuseRefused <= 1'b0;
    end else begin
      fuseRefused <= refuseNow;
      if (acceptNow) begin
        debugFuse <= fuseWrVal;
      end
    end
  end

  p_refuse_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fuseWrReq && fuseWrVal && (|lockState)) |=> (fuseRefused && $stable(debugFuse)));

  p_accept_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (fuseWrReq && !fuseWrVal) |=> (!fuseRefused && !debugFuse));

  p_erase_unlock_r10: assert property (@(posedge clk) disable iff (!rstN)
    chipErase |=> (lockState == '0));

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!chipErase) |=> ((lockState & $past(lockState)) == $past(lockState)));

endmodule

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import dbg_mailbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbxStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] mboxByte,
  output logic              dirty
);

  localparam int LOW_W = DATA_W - 1;

  logic [DATA_W-1:0] mboxQ;
  logic              dirtyQ;
  logic [DATA_W-1:0] stdQ;

  // Mailbox byte and dirty flag: erase first, then write over acknowledge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mboxQ  <= '0;
      dirtyQ <= 1'b0;
    end else if (strb.erase) begin
      mboxQ  <= '0;
      dirtyQ <= 1'b0;
    end else begin
      if (strb.mboxWr) begin
        mboxQ <= wrData;
      end
      if (strb.dirtySet) begin
        dirtyQ <= 1'b1;
      end else if (strb.dirtyClr) begin
        dirtyQ <= 1'b0;
      end
    end
  end

  // Ordinary register sharing the address.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stdQ <= '0;
    end else if (strb.stdWr) begin
      stdQ <= wrData;
    end
  end

  always_comb begin
    if (strb.mboxRdSel) begin
      rdData = {dirtyQ, mboxQ[LOW_W-1:0]};
    end else if (strb.stdRdSel) begin
      rdData = stdQ;
    end else begin
      rdData = '0;
    end
  end

  assign mboxByte = mboxQ;
  assign dirty    = dirtyQ;

  p_dirty_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dirtySet && !strb.erase) |=> dirtyQ);

  p_write_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mboxWr && strb.dirtyClr && !strb.erase) |=> (dirtyQ && mboxQ == $past(wrData)));

  p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dirtyClr && !strb.dirtySet) |=> (!dirtyQ && $stable(mboxQ)));

  p_alias_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.mboxWr && !strb.erase) |=> $stable(mboxQ));

  p_erase_wipe_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.erase |=> (mboxQ == '0 && !dirtyQ));

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbg_mailbox_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int LOCK_N = 2,
  parameter logic [ADDR_W-1:0] MBOX_ADDR = 6'h22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWrEn,
  input  logic              cpuRdEn,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              dbgAccessEn,
  input  logic              dbgRdAck,
  output logic [DATA_W-1:0] dbgData,
  output logic              dbgDirty,
  input  logic              chipErase,
  input  logic              lockProgReq,
  input  logic [LOCK_N-1:0] lockProgBits,
  output logic [LOCK_N-1:0] lockState,
  input  logic              fuseWrReq,
  input  logic              fuseWrVal,
  output logic              debugFuse,
  output logic              fuseRefused
);

  mbxStrobe_t strb;

  mbx_ctrl #(
    .ADDR_W(ADDR_W),
    .LOCK_N(LOCK_N),
    .MBOX_ADDR(MBOX_ADDR)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .cpuAddr(cpuAddr),
    .cpuWrEn(cpuWrEn),
    .cpuRdEn(cpuRdEn),
    .dbgAccessEn(dbgAccessEn),
    .dbgRdAck(dbgRdAck),
    .chipErase(chipErase),
    .lockProgReq(lockProgReq),
    .lockProgBits(lockProgBits),
    .fuseWrReq(fuseWrReq),
    .fuseWrVal(fuseWrVal),
    .strb(strb),
    .lockState(lockState),
    .debugFuse(debugFuse),
    .fuseRefused(fuseRefused)
  );

  mbx_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .wrData(cpuWrData),
    .rdData(cpuRdData),
    .mboxByte(dbgData),
    .dirty(dbgDirty)
  );

endmodule

// File: tb/tb_dbg_mailbox.sv
module tb_dbg_mailbox;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int LOCK_N = 2;
  localparam logic [ADDR_W-1:0] MBX = 6'h22;
  localparam logic [ADDR_W-1:0] OTHER = 6'h05;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic cpuWrEn = 1'b0, cpuRdEn = 1'b0;
  logic [DATA_W-1:0] cpuWrData = '0;
  logic [DATA_W-1:0] cpuRdData;
  logic dbgAccessEn = 1'b0, dbgRdAck = 1'b0;
  logic [DATA_W-1:0] dbgData;
  logic dbgDirty;
  logic chipErase = 1'b0, lockProgReq = 1'b0;
  logic [LOCK_N-1:0] lockProgBits = '0;
  logic [LOCK_N-1:0] lockState;
  logic fuseWrReq = 1'b0, fuseWrVal = 1'b0;
  logic debugFuse, fuseRefused;

  int total = 0;
  int bad = 0;
  logic [DATA_W-1:0] rd;

  always #4 clk = ~clk;

  dbg_mailbox #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_N(LOCK_N), .MBOX_ADDR(MBX)) dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .dbgAccessEn(dbgAccessEn),
    .dbgRdAck(dbgRdAck), .dbgData(dbgData), .dbgDirty(dbgDirty), .chipErase(chipErase),
    .lockProgReq(lockProgReq), .lockProgBits(lockProgBits), .lockState(lockState),
    .fuseWrReq(fuseWrReq), .fuseWrVal(fuseWrVal), .debugFuse(debugFuse),
    .fuseRefused(fuseRefused)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cpuWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1'b1;
    tick();
    cpuWrEn = 1'b0;
  endtask

  task automatic cpuRead(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    cpuAddr = a; cpuRdEn = 1'b1;
    #1 d = cpuRdData;
    cpuRdEn = 1'b0;
  endtask

  task automatic setFuse(input logic v);
    fuseWrVal = v; fuseWrReq = 1'b1;
    tick();
    fuseWrReq = 1'b0;
  endtask

  task automatic ack();
    dbgRdAck = 1'b1;
    tick();
    dbgRdAck = 1'b0;
  endtask

  task automatic erase();
    chipErase = 1'b1;
    tick();
    chipErase = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick();
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    cpuRead(MBX, rd);
    chk("R1 shared read", rd, 0);
    chk("R1 dbgData", dbgData, 0);
    chk("R1 dirty", dbgDirty, 0);
    chk("R1 fuse", debugFuse, 0);
    chk("R1 locks", lockState, 0);

    // R6: path closed, write lands in ordinary register for every byte
    for (int v = 0; v < 256; v++) begin
      cpuWrite(MBX, v[7:0]);
      cpuRead(MBX, rd);
      chk("R6 ordinary reg holds byte", rd, v);
      chk("R6 mailbox untouched", dbgData, 0);
      chk("R6 dirty untouched", dbgDirty, 0);
    end

    // R11 / open path
    setFuse(1'b1);
    chk("R11 fuse set no locks", debugFuse, 1);
    chk("R11 no refusal", fuseRefused, 0);
    dbgAccessEn = 1'b1;

    // R2, R3, R4 sweep
    for (int v = 0; v < 256; v++) begin
      cpuWrite(MBX, v[7:0]);
      chk("R2 dbgData", dbgData, v);
      chk("R2 dirty set", dbgDirty, 1);
      cpuRead(MBX, rd);
      chk("R3 read with dirty", rd, 128 + (v % 128));
      ack();
      chk("R4 dirty cleared", dbgDirty, 0);
      chk("R4 byte kept", dbgData, v);
      cpuRead(MBX, rd);
      chk("R3 read clean", rd, v % 128);
    end

    // R5 write and acknowledge together
    cpuAddr = MBX; cpuWrData = 8'hA5; cpuWrEn = 1'b1; dbgRdAck = 1'b1;
    tick();
    cpuWrEn = 1'b0; dbgRdAck = 1'b0;
    chk("R5 dirty stays", dbgDirty, 1);
    chk("R5 new byte", dbgData, 8'hA5);

    // R6 all four fuse/access combinations; ordinary reg last held 0xFF
    for (int c = 0; c < 4; c++) begin
      logic open;
      logic [7:0] v;
      setFuse(c[1]);
      dbgAccessEn = c[0];
      open = c[1] & c[0];
      v = 8'h30 + 8'(c);
      cpuWrite(MBX, v);
      if (open) begin
        chk("R6 open mailbox", dbgData, v);
      end else begin
        chk("R6 closed mailbox kept", dbgData, 8'hA5);
        cpuRead(MBX, rd);
        chk("R6 closed ordinary", rd, v);
      end
    end
    // now fuse=1, access=1, mailbox=0x33, ordinary=0x32
    dbgAccessEn = 1'b0;
    cpuRead(MBX, rd);
    chk("R6 ordinary not hit by open write", rd, 8'h32);
    dbgAccessEn = 1'b1;

    // R7 other address
    cpuWrite(OTHER, 8'h77);
    chk("R7 mailbox unchanged", dbgData, 8'h33);
    cpuRead(OTHER, rd);
    chk("R7 other read zero", rd, 0);
    dbgAccessEn = 1'b0;
    cpuRead(MBX, rd);
    chk("R7 ordinary unchanged", rd, 8'h32);
    dbgAccessEn = 1'b1;

    // R8, R9, R10 for every non-zero lock pattern
    for (int p = 1; p < 4; p++) begin
      setFuse(1'b0);
      chk("R11 fuse clear", debugFuse, 0);
      lockProgBits = p[1:0]; lockProgReq = 1'b1;
      tick();
      lockProgReq = 1'b0;
      chk("R8 locks programmed", lockState, p);
      lockProgBits = 2'b00; lockProgReq = 1'b1;
      tick();
      lockProgReq = 1'b0;
      chk("R8 locks sticky", lockState, p);
      setFuse(1'b1);
      chk("R9 refused pulse", fuseRefused, 1);
      chk("R9 fuse unchanged", debugFuse, 0);
      tick();
      chk("R9 pulse one cycle", fuseRefused, 0);
      erase();
      chk("R10 locks cleared", lockState, 0);
      chk("R10 mailbox cleared", dbgData, 0);
      chk("R10 fuse kept", debugFuse, 0);
      setFuse(1'b1);
      chk("R10 fuse accepted", debugFuse, 1);
      chk("R10 no refusal", fuseRefused, 0);
      cpuWrite(MBX, 8'h5A + 8'(p));
    end

    // R10 erase beats write; ordinary register kept
    cpuAddr = MBX; cpuWrData = 8'hEE; cpuWrEn = 1'b1; chipErase = 1'b1;
    tick();
    cpuWrEn = 1'b0; chipErase = 1'b0;
    chk("R10 erase wins byte", dbgData, 0);
    chk("R10 erase wins dirty", dbgDirty, 0);
    dbgAccessEn = 1'b0;
    cpuRead(MBX, rd);
    chk("R10 ordinary kept", rd, 8'h32);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule